// File: doc/BRIEF.md
# Key-Protected Watchdog Configuration Port

This block is a small configuration space that software reaches through two byte-wide ports. One port holds the address of a register and the other carries its data. All access is fenced by a key sequence. Software opens the space by writing the opening key twice in a row to the index port. It then picks the watchdog page through a page-select register, and programs four things: the counting unit, the timeout value, which peripheral interrupts may reload the timer, and the run bit. Writing the closing key to the index port seals the space again.

The timer counts down on ticks of the chosen unit: either a seconds tick or a minutes tick, both generated outside. It runs only while the run bit is set and the board's safety-jumper input is high. Software keeps it alive by rewriting the timeout value. The timer can also be reloaded by keyboard or mouse interrupt strobes when those sources are enabled. When the count runs out, the block emits a one-cycle reset pulse. The counter then sits at zero until it is reprogrammed or the timer is stopped.

Top module: `cfgport_wdt`

## Requirements
- R1: After reset the space is sealed, `rd_byte` reads 0xFF, `wdt_rst` is 0, and the page, run bit, unit bit, timeout value and source enables are all 0.
- R2: Two consecutive index-port writes of 0x87 open the space. Any other index byte, or any data-port write, between the two key writes restarts the sequence.
- R3: An index-port write of 0xAA while open seals the space. While sealed, data-port writes change nothing and `rd_byte` reads 0xFF.
- R4: While open, index 0x07 is the page register (read/write, any page). Registers 0x30, 0xF5, 0xF6 and 0xF7 exist only when the page holds 0x08. On any other page their writes are ignored and they read 0xFF. Unmapped indices read 0xFF.
- R5: Register 0x30 bit 0 is the run bit. It reads back as 0x00 or 0x01.
- R6: Register 0xF5 bit 3 is the unit: 0 = seconds tick, 1 = minutes tick. Only that bit is stored, so it reads back as 0x00 or 0x08.
- R7: Register 0xF6 is the 8-bit timeout value and reads back as written.
- R8: Register 0xF7 bit 6 lets a `kbd_irq` strobe reload the counter from the timeout value, and bit 7 does the same for `mouse_irq`. Only those two bits read back. A strobe whose bit is clear has no effect.
- R9: The timer runs only while the run bit and `jumper_ok` are both 1. Otherwise the counter holds the timeout value and no pulse is issued.
- R10: While running, the counter drops by one on each tick of the selected unit. The tick of the other unit is ignored.
- R11: A tick that takes the counter from 1 to 0 raises `wdt_rst` for exactly the next cycle. The counter then stays at 0 with no further pulse until it is reloaded or stopped.
- R12: Writing 0xF6 while running restarts the countdown from the newly written value.
- R13: A timeout value of 0 never produces a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx_wr | input | 1 | Index-port write strobe |
| data_wr | input | 1 | Data-port write strobe |
| wr_byte | input | 8 | Byte written to either port |
| rd_byte | output | 8 | Data-port read value for the current index |
| tick_sec | input | 1 | Seconds tick, one cycle wide |
| tick_min | input | 1 | Minutes tick, one cycle wide |
| kbd_irq | input | 1 | Keyboard interrupt strobe |
| mouse_irq | input | 1 | Mouse interrupt strobe |
| jumper_ok | input | 1 | Safety-jumper level, 1 = watchdog allowed |
| wdt_rst | output | 1 | Reset pulse on expiry |

## Verification
The assertions watch the following on every cycle: that the space only opens right after an opening-key write, and that the closing key seals it. They also check that a sealed space reads 0xFF and that gated data writes leave the registers alone. On the timer side they check that a running counter steps down by exactly one per selected tick, that it rests at zero, and that the reset pulse is a single cycle wide and never appears while the timer is stopped. Other behaviour shows only in the bench scenarios. These are: a broken key sequence leaving the space sealed, the exact tick on which the pulse lands, keepalive and interrupt reloads postponing it, the unselected unit's tick being ignored, and a zero timeout never firing.

// File: rtl/cpw_pkg.sv
package cpw_pkg;
   typedef enum logic [1:0] {
      KS_SEALED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam int NUM_SRC = 2;
   localparam int SRC_KBD = 0;
   localparam int SRC_MOUSE = 1;
endpackage

// File: rtl/cpw_keylock.sv
module cpw_keylock
   import cpw_pkg::*;
#(
   parameter int W = 8,
   parameter logic [W-1:0] KEY_OPEN = 8'h87,
   parameter logic [W-1:0] KEY_CLOSE = 8'hAA
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         idx_wr,
   input  logic         data_wr,
   input  logic [W-1:0] wr_byte,
   output logic         cfg_open,
   output logic [W-1:0] sel_idx
);
   key_state_e state;

   generate
      if (KEY_OPEN == KEY_CLOSE) begin : g_bad_keys
         $error("cpw_keylock: open and close keys must differ");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= KS_SEALED;
         sel_idx <= '0;
      end else if (idx_wr) begin
         unique case (state)
            KS_SEALED: state <= (wr_byte == KEY_OPEN) ? KS_HALF : KS_SEALED;
            KS_HALF:   state <= (wr_byte == KEY_OPEN) ? KS_OPEN : KS_SEALED;
            KS_OPEN: begin
               if (wr_byte == KEY_CLOSE) state <= KS_SEALED;
               else sel_idx <= wr_byte;
            end
            default:   state <= KS_SEALED;
         endcase
      end else if (data_wr && state == KS_HALF) begin
         state <= KS_SEALED;
      end
   end

   assign cfg_open = (state == KS_OPEN);

   // R2: the space opens only on the cycle after an opening-key write
   a_r2_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_open) |-> $past(idx_wr && wr_byte == KEY_OPEN));

   // R3: the closing key seals an open space
   a_r3_close_seals: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_open && idx_wr && wr_byte == KEY_CLOSE) |=> !cfg_open);
endmodule

// File: rtl/cpw_regs.sv
module cpw_regs
   import cpw_pkg::*;
#(
   parameter int W = 8,
   parameter logic [W-1:0] IDX_PAGE = 8'h07,
   parameter logic [W-1:0] PAGE_WDT = 8'h08,
   parameter logic [W-1:0] IDX_RUN  = 8'h30,
   parameter logic [W-1:0] IDX_UNIT = 8'hF5,
   parameter logic [W-1:0] IDX_CNT  = 8'hF6,
   parameter logic [W-1:0] IDX_SRC  = 8'hF7,
   parameter int RUN_BIT  = 0,
   parameter int UNIT_BIT = 3,
   parameter int KBD_BIT  = 6,
   parameter int MOUSE_BIT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_open,
   input  logic [W-1:0]       sel_idx,
   input  logic               idx_wr,
   input  logic               data_wr,
   input  logic [W-1:0]       wr_byte,
   output logic               run_bit,
   output logic               unit_min,
   output logic [W-1:0]       cnt_val,
   output logic [NUM_SRC-1:0] src_en,
   output logic               cnt_wr,
   output logic [W-1:0]       rd_byte
);
   localparam logic [W-1:0] ALL_ONES = '1;

   function automatic int src_pos(input int i);
      return (i == SRC_KBD) ? KBD_BIT : MOUSE_BIT;
   endfunction

   logic [W-1:0] page;
   logic         page_hit;
   logic         wr_ok;
   logic [W-1:0] src_rd;

   generate
      if (RUN_BIT >= W || UNIT_BIT >= W || KBD_BIT >= W || MOUSE_BIT >= W) begin : g_bad_bits
         $error("cpw_regs: a field bit lies outside the data width");
      end
      if (KBD_BIT == MOUSE_BIT) begin : g_bad_src
         $error("cpw_regs: interrupt source bits must differ");
      end
   endgenerate

   assign page_hit = (page == PAGE_WDT);
   assign wr_ok    = cfg_open && data_wr && !idx_wr;
   assign cnt_wr   = wr_ok && page_hit && (sel_idx == IDX_CNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         page     <= '0;
         run_bit  <= 1'b0;
         unit_min <= 1'b0;
         cnt_val  <= '0;
      end else if (wr_ok) begin
         if (sel_idx == IDX_PAGE) page <= wr_byte;
         else if (page_hit) begin
            if (sel_idx == IDX_RUN)  run_bit  <= wr_byte[RUN_BIT];
            if (sel_idx == IDX_UNIT) unit_min <= wr_byte[UNIT_BIT];
            if (sel_idx == IDX_CNT)  cnt_val  <= wr_byte;
         end
      end
   end

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
         always_ff @(posedge clk) begin
            if (!rst_n) src_en[i] <= 1'b0;
            else if (wr_ok && page_hit && sel_idx != IDX_PAGE && sel_idx == IDX_SRC)
               src_en[i] <= wr_byte[src_pos(i)];
         end
      end
   endgenerate

   always_comb begin
      src_rd = '0;
      for (int i = 0; i < NUM_SRC; i++) src_rd[src_pos(i)] = src_en[i];
   end

   always_comb begin
      rd_byte = ALL_ONES;
      if (cfg_open) begin
         if (sel_idx == IDX_PAGE) rd_byte = page;
         else if (page_hit) begin
            if (sel_idx == IDX_RUN) begin
               rd_byte = '0;
               rd_byte[RUN_BIT] = run_bit;
            end else if (sel_idx == IDX_UNIT) begin
               rd_byte = '0;
               rd_byte[UNIT_BIT] = unit_min;
            end else if (sel_idx == IDX_CNT) rd_byte = cnt_val;
            else if (sel_idx == IDX_SRC) rd_byte = src_rd;
         end
      end
   end

   // R3: a sealed space reads all ones
   a_r3_sealed_reads_ones: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_open |-> rd_byte == ALL_ONES);

   // R4: gated data writes leave the watchdog registers alone
   a_r4_gated_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (data_wr && !(cfg_open && page_hit)) |=>
         ($stable(run_bit) && $stable(unit_min) && $stable(cnt_val) && $stable(src_en)));
endmodule

// File: rtl/cpw_timer.sv
module cpw_timer
   import cpw_pkg::*;
#(
   parameter int W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_bit,
   input  logic               jumper_ok,
   input  logic               unit_min,
   input  logic               tick_sec,
   input  logic               tick_min,
   input  logic               cnt_wr,
   input  logic [W-1:0]       wr_byte,
   input  logic [W-1:0]       cnt_val,
   input  logic [NUM_SRC-1:0] src_en,
   input  logic [NUM_SRC-1:0] src_irq,
   output logic               wdt_rst
);
   localparam logic [W-1:0] ONE = W'(1);

   logic [W-1:0]       ctr;
   logic [NUM_SRC-1:0] src_hit;
   logic               active;
   logic               reload;
   logic               step;
   logic [W-1:0]       load_val;

   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_hit
         assign src_hit[i] = src_en[i] & src_irq[i];
      end
   endgenerate

   assign active   = run_bit & jumper_ok;
   assign reload   = cnt_wr | (|src_hit) | !active;
   assign load_val = cnt_wr ? wr_byte : cnt_val;
   assign step     = unit_min ? tick_min : tick_sec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctr     <= '0;
         wdt_rst <= 1'b0;
      end else begin
         wdt_rst <= 1'b0;
         if (reload) ctr <= load_val;
         else if (step && ctr != '0) begin
            ctr <= ctr - ONE;
            if (ctr == ONE) wdt_rst <= 1'b1;
         end
      end
   end

   // R10: a running counter steps down by exactly one per selected tick
   a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !reload && step && ctr != '0) |=> ctr == $past(ctr) - ONE);

   // R11: the counter rests at zero until something reloads it
   a_r11_rest_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctr == '0 && !reload) |=> ctr == '0);

   // R11: the reset pulse lasts a single cycle
   a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst);

   // R9: no pulse follows a cycle in which the timer was stopped
   a_r9_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |-> $past(active));
endmodule

// File: rtl/cfgport_wdt.sv
module cfgport_wdt
   import cpw_pkg::*;
#(
   parameter int W = 8,
   parameter logic [W-1:0] KEY_OPEN  = 8'h87,
   parameter logic [W-1:0] KEY_CLOSE = 8'hAA,
   parameter logic [W-1:0] IDX_PAGE  = 8'h07,
   parameter logic [W-1:0] PAGE_WDT  = 8'h08,
   parameter logic [W-1:0] IDX_RUN   = 8'h30,
   parameter logic [W-1:0] IDX_UNIT  = 8'hF5,
   parameter logic [W-1:0] IDX_CNT   = 8'hF6,
   parameter logic [W-1:0] IDX_SRC   = 8'hF7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         idx_wr,
   input  logic         data_wr,
   input  logic [W-1:0] wr_byte,
   output logic [W-1:0] rd_byte,
   input  logic         tick_sec,
   input  logic         tick_min,
   input  logic         kbd_irq,
   input  logic         mouse_irq,
   input  logic         jumper_ok,
   output logic         wdt_rst
);
   logic               cfg_open;
   logic [W-1:0]       sel_idx;
   logic               run_bit;
   logic               unit_min;
   logic [W-1:0]       cnt_val;
   logic [NUM_SRC-1:0] src_en;
   logic [NUM_SRC-1:0] src_irq;
   logic               cnt_wr;

   generate
      if (W < 8) begin : g_bad_width
         $error("cfgport_wdt: data width must be at least 8");
      end
   endgenerate

   assign src_irq[SRC_KBD]   = kbd_irq;
   assign src_irq[SRC_MOUSE] = mouse_irq;

   cpw_keylock #(.W(W), .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_lock (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
      .wr_byte(wr_byte), .cfg_open(cfg_open), .sel_idx(sel_idx)
   );

   cpw_regs #(.W(W), .IDX_PAGE(IDX_PAGE), .PAGE_WDT(PAGE_WDT), .IDX_RUN(IDX_RUN),
              .IDX_UNIT(IDX_UNIT), .IDX_CNT(IDX_CNT), .IDX_SRC(IDX_SRC)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_open(cfg_open), .sel_idx(sel_idx),
      .idx_wr(idx_wr), .data_wr(data_wr), .wr_byte(wr_byte), .run_bit(run_bit),
      .unit_min(unit_min), .cnt_val(cnt_val), .src_en(src_en), .cnt_wr(cnt_wr),
      .rd_byte(rd_byte)
   );

   cpw_timer #(.W(W)) u_timer (
      .clk(clk), .rst_n(rst_n), .run_bit(run_bit), .jumper_ok(jumper_ok),
      .unit_min(unit_min), .tick_sec(tick_sec), .tick_min(tick_min),
      .cnt_wr(cnt_wr), .wr_byte(wr_byte), .cnt_val(cnt_val), .src_en(src_en),
      .src_irq(src_irq), .wdt_rst(wdt_rst)
   );
endmodule

// File: tb/cfgport_wdt_test.sv
module cfgport_wdt_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic idx_wr = 1'b0, data_wr = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic [7:0] rd_byte;
   logic tick_sec = 1'b0, tick_min = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0;
   logic jumper_ok = 1'b0;
   logic wdt_rst;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cfgport_wdt uut (
      .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .data_wr(data_wr),
      .wr_byte(wr_byte), .rd_byte(rd_byte), .tick_sec(tick_sec),
      .tick_min(tick_min), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq),
      .jumper_ok(jumper_ok), .wdt_rst(wdt_rst)
   );

   // behavioural reference: key state 0 sealed, 1 half, 2 open
   int m_key, m_idx, m_page, m_run, m_unit, m_cnt, m_kbd, m_mouse, m_ctr, m_pulse;
   int m_act, m_rl, m_step;

   function automatic int m_read();
      if (m_key != 2) return 255;
      if (m_idx == 8'h07) return m_page;
      if (m_page != 8'h08) return 255;
      case (m_idx)
         8'h30: return m_run;
         8'hF5: return m_unit * 8;
         8'hF6: return m_cnt;
         8'hF7: return m_kbd * 64 + m_mouse * 128;
         default: return 255;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_key = 0; m_idx = 0; m_page = 0; m_run = 0; m_unit = 0;
         m_cnt = 0; m_kbd = 0; m_mouse = 0; m_ctr = 0; m_pulse = 0;
      end else begin
         m_act = (m_run == 1 && jumper_ok) ? 1 : 0;
         m_step = (m_unit == 1) ? int'(tick_min) : int'(tick_sec);
         m_pulse = 0;
         if (data_wr && !idx_wr && m_key == 2 && m_page == 8'h08 && m_idx == 8'hF6) begin
            m_ctr = wr_byte;
         end else if ((kbd_irq && m_kbd == 1) || (mouse_irq && m_mouse == 1) || m_act == 0) begin
            m_ctr = m_cnt;
         end else if (m_step == 1 && m_ctr > 0) begin
            m_ctr = m_ctr - 1;
            if (m_ctr == 0) m_pulse = 1;
         end
         if (idx_wr) begin
            if (m_key == 0) m_key = (wr_byte == 8'h87) ? 1 : 0;
            else if (m_key == 1) m_key = (wr_byte == 8'h87) ? 2 : 0;
            else if (wr_byte == 8'hAA) m_key = 0;
            else m_idx = wr_byte;
         end else if (data_wr) begin
            if (m_key == 1) m_key = 0;
            else if (m_key == 2) begin
               if (m_idx == 8'h07) m_page = wr_byte;
               else if (m_page == 8'h08) begin
                  if (m_idx == 8'h30) m_run = wr_byte[0];
                  if (m_idx == 8'hF5) m_unit = wr_byte[3];
                  if (m_idx == 8'hF6) m_cnt = wr_byte;
                  if (m_idx == 8'hF7) begin
                     m_kbd = wr_byte[6];
                     m_mouse = wr_byte[7];
                  end
               end
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         checks++;
         if (int'(rd_byte) != m_read()) begin
            errors++;
            $display("FAIL R7 model read: actual %02h expected %02h", rd_byte, m_read());
         end
         checks++;
         if (int'(wdt_rst) != m_pulse) begin
            errors++;
            $display("FAIL R11 model pulse: actual %0d expected %0d", wdt_rst, m_pulse);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic iw(input logic [7:0] b);
      idx_wr = 1'b1; wr_byte = b;
      @(negedge clk);
      idx_wr = 1'b0;
   endtask

   task automatic dw(input logic [7:0] b);
      data_wr = 1'b1; wr_byte = b;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic wreg(input logic [7:0] i, input logic [7:0] v);
      iw(i);
      dw(v);
   endtask

   task automatic ts();
      tick_sec = 1'b1;
      @(negedge clk);
      tick_sec = 1'b0;
   endtask

   task automatic tm();
      tick_min = 1'b1;
      @(negedge clk);
      tick_min = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 sealed read", rd_byte, 8'hFF);
      chk("R1 pulse low", wdt_rst, 0);

      // R3: writes while sealed are ignored
      iw(8'h30); dw(8'h01);
      chk("R3 sealed read", rd_byte, 8'hFF);

      // R2: broken key sequence restarts
      iw(8'h87); iw(8'h12); iw(8'h87);
      iw(8'h07);
      chk("R2 broken key stays sealed", rd_byte, 8'hFF);
      iw(8'h87); dw(8'h00); iw(8'h87);
      chk("R2 data write breaks key", rd_byte, 8'hFF);
      iw(8'h87); iw(8'h87);
      iw(8'h07);
      chk("R1 page after reset", rd_byte, 8'h00);

      // R4: foreign page hides the watchdog registers
      dw(8'h05);
      chk("R4 page reads back", rd_byte, 8'h05);
      wreg(8'h30, 8'h01);
      chk("R4 foreign page reads ones", rd_byte, 8'hFF);
      wreg(8'h07, 8'h08);
      iw(8'h30);
      chk("R4 foreign write ignored", rd_byte, 8'h00);
      iw(8'h55);
      chk("R4 unmapped reads ones", rd_byte, 8'hFF);

      wreg(8'hF5, 8'hFF);
      chk("R6 unit reads bit 3", rd_byte, 8'h08);
      wreg(8'hF5, 8'h00);
      wreg(8'hF6, 8'h03);
      chk("R7 count reads back", rd_byte, 8'h03);
      wreg(8'hF7, 8'hFF);
      chk("R8 sources read bits 7:6", rd_byte, 8'hC0);
      wreg(8'hF7, 8'h00);
      wreg(8'h30, 8'hFF);
      chk("R5 run reads bit 0", rd_byte, 8'h01);

      // R9: jumper low keeps the timer stopped
      repeat (5) begin
         ts();
         chk("R9 no pulse without jumper", wdt_rst, 0);
      end
      jumper_ok = 1'b1;
      @(negedge clk);
      // R10: other unit ignored, seconds count
      repeat (3) begin
         tm();
         chk("R10 minute tick ignored", wdt_rst, 0);
      end
      ts(); ts();
      chk("R10 two ticks no pulse", wdt_rst, 0);
      ts();
      chk("R11 pulse on expiry", wdt_rst, 1);
      @(negedge clk);
      chk("R11 pulse one cycle", wdt_rst, 0);
      repeat (3) begin
         ts();
         chk("R11 rests at zero", wdt_rst, 0);
      end

      // R12: keepalive restarts the countdown
      wreg(8'hF6, 8'h03);
      ts(); ts();
      wreg(8'hF6, 8'h03);
      ts(); ts();
      chk("R12 keepalive postpones", wdt_rst, 0);
      ts();
      chk("R12 expiry after keepalive", wdt_rst, 1);

      // R8: disabled keyboard source ignored
      wreg(8'hF6, 8'h02);
      ts();
      kbd_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0;
      ts();
      chk("R8 disabled kbd ignored", wdt_rst, 1);
      wreg(8'hF7, 8'h40);
      wreg(8'hF6, 8'h02);
      ts();
      kbd_irq = 1'b1; @(negedge clk); kbd_irq = 1'b0;
      ts();
      chk("R8 kbd reload", wdt_rst, 0);
      ts();
      chk("R8 expiry after kbd", wdt_rst, 1);
      wreg(8'hF7, 8'h80);
      wreg(8'hF6, 8'h02);
      ts();
      mouse_irq = 1'b1; @(negedge clk); mouse_irq = 1'b0;
      ts();
      chk("R8 mouse reload", wdt_rst, 0);
      ts();
      chk("R8 expiry after mouse", wdt_rst, 1);

      // R9: stopping reloads the counter
      wreg(8'hF6, 8'h02);
      ts();
      wreg(8'h30, 8'h00);
      wreg(8'h30, 8'h01);
      ts();
      chk("R9 stop reloads", wdt_rst, 0);
      ts();
      chk("R9 expiry after restart", wdt_rst, 1);

      // R3: sealing ignores a would-be keepalive
      wreg(8'hF6, 8'h02);
      ts();
      iw(8'hAA);
      chk("R3 sealed after close key", rd_byte, 8'hFF);
      dw(8'h05);
      ts();
      chk("R3 sealed write no keepalive", wdt_rst, 1);

      // R13: zero timeout never fires
      iw(8'h87); iw(8'h87);
      wreg(8'hF6, 8'h00);
      repeat (3) begin
         ts();
         chk("R13 zero never fires", wdt_rst, 0);
      end

      // R6: minutes unit
      wreg(8'hF5, 8'h08);
      wreg(8'hF6, 8'h02);
      ts(); ts();
      chk("R6 seconds ignored in minutes", wdt_rst, 0);
      tm(); tm();
      chk("R6 minutes expiry", wdt_rst, 1);

      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule